// File: doc/BRIEF.md
# Accumulator ALU with skip logic

This block carries out the data step of an 8-bit accumulator machine. Each cycle it takes a 13-bit instruction word, the accumulator, the byte read from the addressed register and the current carry flag. It decodes the register-class, bit-class and literal-class opcodes and computes the new byte. It then says where that byte goes (accumulator or register), which of the Z, DC and C flags change and to what, and whether the following instruction must be skipped. The surrounding core owns the program counter, the register file and the flag register. It applies the write enables, the flag mask and the skip request that this block presents.

All outputs are registered. They show the result for the inputs sampled at the previous rising clock edge, so the block fits one pipeline stage. A synchronous, active-high reset clears every output.

Top module: `acc_alu`

## Requirements
- R1: While reset is high at a rising edge, every output becomes zero in the following cycle, whatever instruction is presented.
- R2: Outputs reflect the instruction, accumulator, register byte and carry sampled at the previous rising edge, with no other delay.
- R3: For register-class instructions (instr[12:11]=00, operation code instr[10:7] in 0101..1111), instr[6]=0 raises wr_acc and instr[6]=1 raises wr_reg. Bit clear and bit set raise wr_reg. Literal instructions raise wr_acc.
- R4: Logic and move operations update only Z (flag_mask=100, where flag_mask[2]=Z, [1]=DC, [0]=C). Register class: code 0101 gives A AND R, 0110 gives A XOR R, 1000 passes R, 1001 gives NOT R. Literal class (instr[12:11]=11, code instr[10:8], k=instr[7:0]): 000 gives k, 001 gives A OR k, 010 gives A AND k, 011 gives A XOR k.
- R5: Addition (register code 0111, A+R; literal code 111, k+A) sets C to the carry out of bit 7 and DC to the carry out of bit 3. It sets Z when the byte is zero, with flag_mask=111.
- R6: Literal code 101 gives k−A. C=1 means k≥A (no borrow) and DC=1 means k[3:0]≥A[3:0]. Z is set on a zero result, with flag_mask=111.
- R7: Code 1010 gives R+1 and updates Z only. Code 1011 gives R−1 and code 1111 gives R+1. Both leave all flags unchanged and raise skip_req when the result is zero.
- R8: Code 1100 rotates right through carry: the new bit 7 is the old C and the new C is R[0]. Code 1101 rotates left through carry: the new bit 0 is the old C and the new C is R[7]. Both use flag_mask=001.
- R9: Code 1110 exchanges the two nibbles of R, with flag_mask=000.
- R10: Bit class (instr[12:11]=01, code instr[10:9], bit index instr[8:6]): code 00 writes R with the bit cleared and code 01 writes R with the bit set. Neither changes a flag or raises skip_req.
- R11: Bit code 10 raises skip_req when the indexed bit of R is 0, and code 11 raises it when that bit is 1. Neither raises a write enable or changes a flag, and result is 0.
- R12: Register codes 0000..0100, literal codes 100 and 110, and every word with instr[12:11]=10 raise no write enable, no flag and no skip, and result is 0.
- R13: A flag output whose mask bit is 0 reads 0. When neither write enable is raised, result reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | IW (13) | Instruction word |
| acc_in | input | DW (8) | Current accumulator |
| reg_in | input | DW (8) | Byte read from the addressed register |
| carry_in | input | 1 | Current carry flag |
| result | output | DW (8) | Computed byte |
| wr_acc | output | 1 | Write result to the accumulator |
| wr_reg | output | 1 | Write result back to the register |
| z_out | output | 1 | New Z value (valid where flag_mask[2]) |
| dc_out | output | 1 | New DC value (valid where flag_mask[1]) |
| c_out | output | 1 | New C value (valid where flag_mask[0]) |
| flag_mask | output | 3 | Flags to update: [2]=Z, [1]=DC, [0]=C |
| skip_req | output | 1 | Skip the next instruction |

## Verification
A write-back and a skip request can fall in the same cycle. Decrement-and-skip or increment-and-skip writes its byte and also requests a skip when that byte is zero, while the flag mask stays clear even though the result is zero. The sweep runs every one of the 8192 instruction words against several register values, including ones that wrap to zero under increment and decrement. Each cycle is judged by comparing the complete output vector (result, both write enables, the three flags, the mask and the skip bit) against an arithmetic model built from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_PASS, OP_AND, OP_OR, OP_XOR, OP_COM, OP_ADD, OP_SUB,
    OP_INC, OP_DEC, OP_RRC, OP_RLC, OP_SWAP, OP_BCLR, OP_BSET, OP_BTST
  } alu_op_e;

  typedef enum logic [1:0] {DST_NONE, DST_ACC, DST_REG} dst_e;

  localparam int FLAG_C  = 0;
  localparam int FLAG_DC = 1;
  localparam int FLAG_Z  = 2;

  typedef struct packed {
    alu_op_e    op;
    dst_e       dst;
    logic [2:0] upd;        // flags to update, {Z, DC, C}
    logic       skip_zero;  // skip when result is zero
    logic       test_pol;   // bit test: skip when bit equals this
    logic       src_lit;    // second operand is the literal
  } dec_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int IW   = 13,
  parameter int RA_W = 6
) (
  input  logic [IW-1:RA_W] opc,
  output dec_t             dec
);

  always_comb begin
    dec           = '0;
    dec.op        = OP_NONE;
    dec.dst       = DST_NONE;
    if (!opc[IW-1]) begin
      if (opc[IW-2]) begin
        // bit class: clear, set, test
        unique case (opc[IW-3 -: 2])
          2'b00: begin dec.op = OP_BCLR; dec.dst = DST_REG; end
          2'b01: begin dec.op = OP_BSET; dec.dst = DST_REG; end
          default: begin
            dec.op       = OP_BTST;
            dec.test_pol = opc[IW-4];
          end
        endcase
      end else begin
        dec.dst = opc[RA_W] ? DST_REG : DST_ACC;
        unique case (opc[IW-3 -: 4])
          4'b0101: begin dec.op = OP_AND;  dec.upd = 3'b100; end
          4'b0110: begin dec.op = OP_XOR;  dec.upd = 3'b100; end
          4'b0111: begin dec.op = OP_ADD;  dec.upd = 3'b111; end
          4'b1000: begin dec.op = OP_PASS; dec.upd = 3'b100; end
          4'b1001: begin dec.op = OP_COM;  dec.upd = 3'b100; end
          4'b1010: begin dec.op = OP_INC;  dec.upd = 3'b100; end
          4'b1011: begin dec.op = OP_DEC;  dec.skip_zero = 1'b1; end
          4'b1100: begin dec.op = OP_RRC;  dec.upd = 3'b001; end
          4'b1101: begin dec.op = OP_RLC;  dec.upd = 3'b001; end
          4'b1110: begin dec.op = OP_SWAP; end
          4'b1111: begin dec.op = OP_INC;  dec.skip_zero = 1'b1; end
          default: begin dec.op = OP_NONE; dec.dst = DST_NONE; end
        endcase
      end
    end else if (opc[IW-2]) begin
      dec.src_lit = 1'b1;
      dec.dst     = DST_ACC;
      unique case (opc[IW-3 -: 3])
        3'b000: begin dec.op = OP_PASS; dec.upd = 3'b100; end
        3'b001: begin dec.op = OP_OR;   dec.upd = 3'b100; end
        3'b010: begin dec.op = OP_AND;  dec.upd = 3'b100; end
        3'b011: begin dec.op = OP_XOR;  dec.upd = 3'b100; end
        3'b101: begin dec.op = OP_SUB;  dec.upd = 3'b111; end
        3'b111: begin dec.op = OP_ADD;  dec.upd = 3'b111; end
        default: begin dec.op = OP_NONE; dec.dst = DST_NONE; dec.src_lit = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hcout
);

  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic [H:0]  lo;
  logic [HU:0] hi;

  always_comb begin
    lo    = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
    hi    = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{HU{1'b0}}, lo[H]};
    sum   = {hi[HU-1:0], lo[H-1:0]};
    cout  = hi[HU];
    hcout = lo[H];
  end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e              op,
  input  logic [W-1:0]         b,
  input  logic                 cin,
  input  logic [$clog2(W)-1:0] idx,
  output logic [W-1:0]         res,
  output logic                 cout,
  output logic                 tbit
);

  localparam int H    = W / 2;
  localparam int IDXW = $clog2(W);

  logic [W-1:0] onehot;

  for (genvar g = 0; g < W; g++) begin : g_sel
    assign onehot[g] = (idx == IDXW'(g));
  end

  always_comb begin
    res  = b;
    cout = 1'b0;
    case (op)
      OP_RRC:  begin res = {cin, b[W-1:1]}; cout = b[0];   end
      OP_RLC:  begin res = {b[W-2:0], cin}; cout = b[W-1]; end
      OP_SWAP: res = {b[H-1:0], b[W-1:H]};
      OP_BCLR: res = b & ~onehot;
      OP_BSET: res = b | onehot;
      default: res = b;
    endcase
    tbit = |(b & onehot);
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IW   = 13,
  parameter int RA_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] reg_in,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          wr_acc,
  output logic          wr_reg,
  output logic          z_out,
  output logic          dc_out,
  output logic          c_out,
  output logic [2:0]    flag_mask,
  output logic          skip_req
);

  localparam int IDXW = $clog2(DW);

  dec_t            dec;
  logic [DW-1:0]   opnd;
  logic [DW-1:0]   add_x, add_y, add_sum;
  logic            add_ci, add_co, add_hco;
  logic [DW-1:0]   bit_res;
  logic            bit_co, bit_t;
  logic [DW-1:0]   res_nx;
  logic            carry_nx, zero_nx, skip_nx, any_wr;

  acc_alu_decode #(.IW(IW), .RA_W(RA_W)) u_dec (
    .opc (instr[IW-1:RA_W]),
    .dec (dec)
  );

  assign opnd = dec.src_lit ? instr[DW-1:0] : reg_in;

  always_comb begin
    add_x  = acc_in;
    add_y  = opnd;
    add_ci = 1'b0;
    case (dec.op)
      OP_SUB: begin add_x = opnd; add_y = ~acc_in; add_ci = 1'b1; end
      OP_INC: begin add_x = opnd; add_y = '0;      add_ci = 1'b1; end
      OP_DEC: begin add_x = opnd; add_y = '1;      add_ci = 1'b0; end
      default: ;
    endcase
  end

  acc_alu_adder #(.W(DW)) u_add (
    .x     (add_x),
    .y     (add_y),
    .cin   (add_ci),
    .sum   (add_sum),
    .cout  (add_co),
    .hcout (add_hco)
  );

  acc_alu_bitops #(.W(DW)) u_bit (
    .op   (dec.op),
    .b    (opnd),
    .cin  (carry_in),
    .idx  (instr[RA_W +: IDXW]),
    .res  (bit_res),
    .cout (bit_co),
    .tbit (bit_t)
  );

  always_comb begin
    case (dec.op)
      OP_PASS:                          res_nx = opnd;
      OP_AND:                           res_nx = acc_in & opnd;
      OP_OR:                            res_nx = acc_in | opnd;
      OP_XOR:                           res_nx = acc_in ^ opnd;
      OP_COM:                           res_nx = ~opnd;
      OP_ADD, OP_SUB, OP_INC, OP_DEC:   res_nx = add_sum;
      OP_RRC, OP_RLC, OP_SWAP,
      OP_BCLR, OP_BSET:                 res_nx = bit_res;
      default:                          res_nx = '0;
    endcase
    carry_nx = ((dec.op == OP_ADD) || (dec.op == OP_SUB)) ? add_co : bit_co;
    zero_nx  = (res_nx == '0);
    skip_nx  = (dec.skip_zero & zero_nx) |
               ((dec.op == OP_BTST) & (bit_t == dec.test_pol));
    any_wr   = (dec.dst != DST_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_acc    <= 1'b0;
      wr_reg    <= 1'b0;
      z_out     <= 1'b0;
      dc_out    <= 1'b0;
      c_out     <= 1'b0;
      flag_mask <= '0;
      skip_req  <= 1'b0;
    end else begin
      result    <= any_wr ? res_nx : '0;
      wr_acc    <= (dec.dst == DST_ACC);
      wr_reg    <= (dec.dst == DST_REG);
      z_out     <= dec.upd[FLAG_Z]  & zero_nx;
      dc_out    <= dec.upd[FLAG_DC] & add_hco;
      c_out     <= dec.upd[FLAG_C]  & carry_nx;
      flag_mask <= dec.upd;
      skip_req  <= skip_nx;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW   = 8,
  parameter int IW   = 13,
  parameter int RA_W = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] acc_in,
  input logic [DW-1:0] reg_in,
  input logic          carry_in,
  input logic [DW-1:0] result,
  input logic          wr_acc,
  input logic          wr_reg,
  input logic          z_out,
  input logic          dc_out,
  input logic          c_out,
  input logic [2:0]    flag_mask,
  input logic          skip_req
);

  localparam int IDXW = $clog2(DW);

  // R1
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (result == '0 && !wr_acc && !wr_reg && !z_out && !dc_out &&
             !c_out && flag_mask == 3'b000 && !skip_req));

  // R3
  a_r3_dest: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 2] == 2'b00 && instr[IW-3 -: 4] >= 4'd5))
    |-> (wr_reg == $past(instr[RA_W]) && wr_acc == !$past(instr[RA_W])));

  // R6
  a_r6_sub: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 5] == 5'b11101))
    |-> (result == DW'($past(instr[DW-1:0]) - $past(acc_in)) &&
         c_out == ($past(instr[DW-1:0]) >= $past(acc_in)) && flag_mask == 3'b111));

  // R7
  a_r7_djz: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 6] == 6'b001011))
    |-> (flag_mask == 3'b000 && skip_req == (result == '0) &&
         result == DW'($past(reg_in) - DW'(1))));

  // R8
  a_r8_rrc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 6] == 6'b001100))
    |-> (flag_mask == 3'b001 && c_out == $past(reg_in[0]) &&
         result[DW-1] == $past(carry_in)));

  // R11
  a_r11_test: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 3] == 3'b011))
    |-> (!wr_acc && !wr_reg && flag_mask == 3'b000 &&
         skip_req == ($past(reg_in[instr[RA_W +: IDXW]]) == $past(instr[IW-4]))));

  // R12
  a_r12_unknown: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[IW-1 -: 2] == 2'b10))
    |-> (!wr_acc && !wr_reg && flag_mask == 3'b000 && !skip_req && result == '0));

  // R13
  a_r13_masked: assert property (@(posedge clk) disable iff (rst)
    ((z_out & ~flag_mask[2]) | (dc_out & ~flag_mask[1]) | (c_out & ~flag_mask[0])) == 1'b0);

endmodule

bind acc_alu acc_alu_chk #(.DW(DW), .IW(IW), .RA_W(RA_W)) u_chk (.*);

// File: tb/test_acc_alu.sv
module test_acc_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] instr = '0;
  logic [7:0]  acc = '0, rdat = '0;
  logic        cin = 1'b0;
  logic [7:0]  result;
  logic        wr_acc, wr_reg, z_out, dc_out, c_out, skip_req;
  logic [2:0]  flag_mask;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  acc_alu i_acc_alu (
    .clk(clk), .rst(rst), .instr(instr), .acc_in(acc), .reg_in(rdat),
    .carry_in(cin), .result(result), .wr_acc(wr_acc), .wr_reg(wr_reg),
    .z_out(z_out), .dc_out(dc_out), .c_out(c_out), .flag_mask(flag_mask),
    .skip_req(skip_req)
  );

  // Expected {result, wr_acc, wr_reg, z, dc, c, mask[2:0], skip}
  function automatic logic [16:0] model(input logic [12:0] ins, input logic [7:0] a,
                                        input logic [7:0] r, input logic c);
    logic [7:0] v, k; logic [8:0] s;
    logic wa, wrr, zf, cf, dcf, sk, hit; logic [2:0] m; int b;
    v = 0; wa = 0; wrr = 0; cf = 0; dcf = 0; sk = 0; m = 0; hit = 0;
    b = int'(ins[8:6]); k = ins[7:0];
    if (ins[12:11] == 2'b01) begin
      case (ins[10:9])
        2'd0: begin v = r & ~(8'd1 << b); wrr = 1; end
        2'd1: begin v = r | (8'd1 << b); wrr = 1; end
        2'd2: sk = (r[b] == 1'b0);
        default: sk = (r[b] == 1'b1);
      endcase
    end else if (ins[12:11] == 2'b00) begin
      hit = 1;
      case (ins[10:7])
        4'd5:  begin v = a & r; m = 3'b100; end
        4'd6:  begin v = a ^ r; m = 3'b100; end
        4'd7:  begin s = {1'b0, a} + {1'b0, r}; v = s[7:0]; cf = s[8];
                     dcf = ({1'b0, a[3:0]} + {1'b0, r[3:0]}) > 5'd15; m = 3'b111; end
        4'd8:  begin v = r; m = 3'b100; end
        4'd9:  begin v = ~r; m = 3'b100; end
        4'd10: begin v = r + 8'd1; m = 3'b100; end
        4'd11: begin v = r - 8'd1; sk = (v == 0); end
        4'd12: begin v = {c, r[7:1]}; cf = r[0]; m = 3'b001; end
        4'd13: begin v = {r[6:0], c}; cf = r[7]; m = 3'b001; end
        4'd14: v = {r[3:0], r[7:4]};
        4'd15: begin v = r + 8'd1; sk = (v == 0); end
        default: hit = 0;
      endcase
      if (hit) begin wa = !ins[6]; wrr = ins[6]; end
    end else if (ins[12:11] == 2'b11) begin
      hit = 1;
      case (ins[10:8])
        3'd0: begin v = k; m = 3'b100; end
        3'd1: begin v = a | k; m = 3'b100; end
        3'd2: begin v = a & k; m = 3'b100; end
        3'd3: begin v = a ^ k; m = 3'b100; end
        3'd5: begin v = k - a; cf = (k >= a); dcf = (k[3:0] >= a[3:0]); m = 3'b111; end
        3'd7: begin s = {1'b0, k} + {1'b0, a}; v = s[7:0]; cf = s[8];
                    dcf = ({1'b0, a[3:0]} + {1'b0, k[3:0]}) > 5'd15; m = 3'b111; end
        default: hit = 0;
      endcase
      wa = hit;
    end
    zf = m[2] && (v == 8'd0);
    if (!(wa || wrr)) v = 8'd0;
    return {v, wa, wrr, zf, dcf, cf, m, sk};
  endfunction

  function automatic string cls(input logic [12:0] ins);
    if (ins[12:11] == 2'b01) return (ins[10] ? "R11" : "R10");
    if (ins[12:11] == 2'b10) return "R12";
    if (ins[12:11] == 2'b11) begin
      case (ins[10:8])
        3'd5: return "R6";
        3'd7: return "R5";
        3'd4, 3'd6: return "R12";
        default: return "R4";
      endcase
    end
    case (ins[10:7])
      4'd5, 4'd6, 4'd8, 4'd9: return "R4";
      4'd7: return "R5";
      4'd10, 4'd11, 4'd15: return "R7";
      4'd12, 4'd13: return "R8";
      4'd14: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic run(input logic [12:0] ins, input logic [7:0] a, input logic [7:0] r,
                     input logic c, input string tag);
    logic [16:0] e, g; string t;
    instr = ins; acc = a; rdat = r; cin = c;
    @(posedge clk); @(negedge clk);
    e = model(ins, a, r, c);
    g = {result, wr_acc, wr_reg, z_out, dc_out, c_out, flag_mask, skip_req};
    t = (tag == "") ? cls(ins) : tag;
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s instr=%h a=%h r=%h c=%b got=%h exp=%h", t, ins, a, r, c, g, e);
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: an adding literal during reset must not reach the outputs
    instr = 13'b1_1111_0000_0101; acc = 8'h10;
    repeat (3) @(negedge clk);
    checks++;
    if ({result, wr_acc, wr_reg, z_out, dc_out, c_out, flag_mask, skip_req} !== 17'd0) begin
      fails++;
      $display("FAIL R1 got=%h exp=0",
               {result, wr_acc, wr_reg, z_out, dc_out, c_out, flag_mask, skip_req});
    end
    rst = 1'b0;
    // R2: first word after reset appears one edge later
    run(13'b1_1111_0000_0101, 8'h10, 8'h00, 1'b0, "R2");
    // R3: same AND to accumulator, then back to the register
    run(13'b0_0010_10_000001, 8'hf0, 8'h3c, 1'b0, "R3");
    run(13'b0_0010_11_000001, 8'hf0, 8'h3c, 1'b0, "R3");
    // R13: rotate giving zero must not report Z
    run(13'b0_0110_00_000010, 8'h00, 8'h01, 1'b0, "R13");
    // R7: decrement to zero writes and skips together
    run(13'b0_0101_11_000011, 8'h00, 8'h01, 1'b0, "R7");
    run(13'b0_0111_11_000011, 8'h00, 8'hff, 1'b0, "R7");
    // every instruction word against several data sets
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8192; i++)
        run(13'(i), 8'(i * 7 + s * 61), (s == 3) ? 8'(i[0] ? 8'hff : 8'h01) : 8'(i * 13 + s * 97 + 3),
            s[0], "");
    // R6: full subtraction sweep
    for (int k = 0; k < 256; k++)
      for (int a = 0; a < 256; a++)
        run({5'b11101, 8'(k)}, 8'(a), 8'h00, 1'b0, "R6");
    // R5: addition from register, every accumulator, even register values
    for (int a = 0; a < 256; a++)
      for (int r = 0; r < 256; r += 2)
        run(13'b0_0011_10_000100, 8'(a), 8'(r), 1'b1, "R5");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule